// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is the receiving side of one port of a network-on-chip router. Flits arrive from a single upstream link, one per cycle at most. Each flit carries a virtual-channel index, a two-bit kind code and a payload. Every virtual channel (VC) has its own FIFO and its own packet state. When the first flit of a packet arrives, a small routing function maps the destination field of the payload to an output port. That port is kept in the VC until the packet's last flit leaves.

A flit waits a configurable number of cycles in its FIFO before the unit offers it to the switch allocator. The allocator sees, for each VC, a ready bit, the front flit and the VC's latched output port. A grant removes the front flit and returns one credit upstream on the following edge. The credit carries the VC index and a flag that says whether the VC is now free.

Illegal arrivals are dropped and flagged. Illegal means a packet start on a busy VC, a continuation on an idle VC, or any flit for a full FIFO. Write and read counters kept per virtual network can be cleared by a statistics-clear input.

Top module: `vcin_unit`

## Requirements
- R1: Kind codes use bit 0 for "starts a packet" and bit 1 for "ends a packet": 00 body, 01 head, 10 tail, 11 single-flit packet. Each accepted flit is stored in its VC's FIFO. The VC's `sa_data`/`sa_kind` slice shows the oldest stored flit, in arrival order.
- R2: A head or single-flit packet on an idle VC makes that VC active. From the next cycle, the VC's `sa_port` slice shows `in_data[DEST_W-1:0] mod NUM_OUT` for the rest of the packet.
- R3: A head or single-flit packet on an active VC is not stored, and `proto_err` is high for the one cycle after that edge.
- R4: A body or tail flit on an idle VC is not stored, and `proto_err` is high for the one cycle after that edge.
- R5: A flit for a VC whose FIFO already holds BUF_DEPTH flits is not stored, and `proto_err` is high for the one cycle after that edge.
- R6: A flit written at edge k reaches the FIFO front and raises its `sa_ready` bit after edge k+PIPE_STAGES-1. With PIPE_STAGES=1 the bit is high right after the write edge.
- R7: A grant bit removes a flit only when the same VC's `sa_ready` bit is high. A grant to a VC that is not ready changes nothing and returns no credit.
- R8: The edge that takes a granted flit raises `credit_valid` for one cycle, with `credit_vc` set to that VC. `credit_free` is 1 exactly when the departing flit ends a packet (kind 10 or 11).
- R9: When a packet-ending flit is granted, its VC becomes idle and its `sa_port` slice reads 0 from the next cycle.
- R10: VC v belongs to virtual network v / VC_PER_VNET. Each stored flit adds one to both that network's write counter and its read counter. Rejected flits add nothing.
- R11: `stats_clr` sets every counter to 0 on the next edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A flit is present on the link this cycle |
| in_vc | input | VC_W | VC index of the arriving flit |
| in_kind | input | 2 | Kind code of the arriving flit |
| in_data | input | DATA_W | Payload; low DEST_W bits are the destination |
| stats_clr | input | 1 | Clear all per-network counters |
| sa_grant | input | NUM_VC | One-hot-or-zero grant from the switch allocator |
| sa_ready | output | NUM_VC | VC front flit may compete for the switch |
| sa_kind | output | 2*NUM_VC | Kind of each VC's front flit |
| sa_data | output | DATA_W*NUM_VC | Payload of each VC's front flit |
| sa_port | output | OUT_W*NUM_VC | Output port latched in each VC |
| credit_valid | output | 1 | Credit returned upstream this cycle |
| credit_vc | output | VC_W | VC the credit belongs to |
| credit_free | output | 1 | The VC is free for a new packet |
| proto_err | output | 1 | Previous cycle's flit was rejected |
| vnet_wr_cnt | output | NUM_VNET*CNT_W | Write counter per virtual network |
| vnet_rd_cnt | output | NUM_VNET*CNT_W | Read counter per virtual network |

## Verification
The bench targets these corner cases:

- **Arrival and departure on one VC in the same cycle.** A design that mishandled it would lose or duplicate a FIFO entry, or would show the hold countdown of the wrong entry.
- **A grant to a VC that is not ready.** A careless design would pop an empty or still-waiting FIFO and send a credit that was never earned.
- **Illegal packet starts and continuations.** A design that stored them would leave the VC state out of step with the upstream sender, visible as a wrong ready bit or output port.
- **Writing into a full FIFO.** A design that accepted the flit would overwrite its oldest entry, and the wrong payload would appear at the front.
- **The free flag and port clearing on the packet-ending flit.** A design that got these wrong would keep a VC busy forever or carry a stale port into the next packet.
- **Both hold depths.** Running with PIPE_STAGES=1 and PIPE_STAGES=2 catches an off-by-one in the hold countdown.
- **A statistics clear that coincides with a write.**

// File: rtl/vcin_pkg.sv
// Shared types and helpers for the VC input port.
// Assumes the kind code layout: bit 0 = starts packet, bit 1 = ends packet.
package vcin_pkg;

    typedef enum logic [1:0] {
        KIND_BODY   = 2'b00,
        KIND_HEAD   = 2'b01,
        KIND_TAIL   = 2'b10,
        KIND_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic {
        VC_IDLE   = 1'b0,
        VC_ACTIVE = 1'b1
    } vc_state_e;

    // True when the flit kind opens a new packet.
    function automatic logic opens_pkt(input logic [1:0] kind);
        return kind[0];
    endfunction

    // True when the flit kind closes its packet.
    function automatic logic closes_pkt(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/vcin_route.sv
// Routing function: maps a destination field to an output port index.
// Purely combinational; assumes NUM_OUT >= 2.
module vcin_route #(
    parameter int DEST_W  = 4,
    parameter int NUM_OUT = 5,
    parameter int OUT_W   = 3
) (
    input  logic [DEST_W-1:0] dest,
    output logic [OUT_W-1:0]  port
);

    // Destination modulo the number of output ports.
    always_comb begin
        port = OUT_W'(32'(dest) % 32'(NUM_OUT));
    end

endmodule

// File: rtl/vcin_lane.sv
// One virtual channel: FIFO, per-entry hold countdown, packet state and
// latched output port. Assumes at most one write and one pop per cycle.
// Illegal or overflowing writes are refused and reported via rejected.
module vcin_lane
    import vcin_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int OUT_W  = 3,
    parameter int HOLD   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OUT_W-1:0]  route_port,
    input  logic              pop_req,
    output logic              accepted,
    output logic              rejected,
    output logic              ready,
    output logic [DATA_W-1:0] front_data,
    output logic [1:0]        front_kind,
    output logic [OUT_W-1:0]  held_port,
    output logic              is_active
);

    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int HOLD_W = (HOLD > 0) ? $clog2(HOLD + 1) : 1;
    localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
    localparam logic [HOLD_W-1:0] HOLD_V   = HOLD_W'(HOLD);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [1:0]        kind_q [DEPTH];
    logic [HOLD_W-1:0] wait_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count;
    vc_state_e         state_q;
    logic [OUT_W-1:0]  port_q;
    logic              legal;
    logic              popping;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Packet-state check for the arriving flit.
    always_comb begin
        legal = opens_pkt(wr_kind) ? (state_q == VC_IDLE) : (state_q == VC_ACTIVE);
    end

    assign accepted   = wr_req && legal && (count != FULL_CNT);
    assign rejected   = wr_req && !accepted;
    assign front_data = data_q[rd_ptr];
    assign front_kind = kind_q[rd_ptr];
    assign ready      = (count != '0) && (wait_q[rd_ptr] == '0);
    assign popping    = pop_req && ready;
    assign held_port  = port_q;
    assign is_active  = (state_q == VC_ACTIVE);

    // FIFO pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) wr_ptr <= bump(wr_ptr);
            if (popping)  rd_ptr <= bump(rd_ptr);
            case ({accepted, popping})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // FIFO storage; contents are don't-care while unoccupied.
    always_ff @(posedge clk) begin
        if (accepted) begin
            data_q[wr_ptr] <= wr_data;
            kind_q[wr_ptr] <= wr_kind;
        end
    end

    // Per-entry countdown that delays eligibility for switch allocation.
    for (genvar i = 0; i < DEPTH; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_q[i] <= '0;
            end else if (accepted && (wr_ptr == PTR_W'(i))) begin
                wait_q[i] <= HOLD_V;
            end else if (wait_q[i] != '0) begin
                wait_q[i] <= wait_q[i] - 1'b1;
            end
        end
    end

    // Packet state and latched output port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VC_IDLE;
            port_q  <= '0;
        end else if (accepted && opens_pkt(wr_kind)) begin
            state_q <= VC_ACTIVE;
            port_q  <= route_port;
        end else if (popping && closes_pkt(kind_q[rd_ptr])) begin
            state_q <= VC_IDLE;
            port_q  <= '0;
        end
    end

endmodule

// File: rtl/vcin_credit.sv
// Registers the upstream credit for the VC that won the switch this cycle.
// Assumes at most one bit of win is set.
module vcin_credit #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] win,
    input  logic [NUM_VC-1:0] win_closes,
    output logic              credit_valid,
    output logic [VC_W-1:0]   credit_vc,
    output logic              credit_free
);

    logic [VC_W-1:0] idx;
    logic            frees;

    // Encode the winning VC and its free flag.
    always_comb begin
        idx   = '0;
        frees = 1'b0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (win[v]) begin
                idx   = VC_W'(v);
                frees = win_closes[v];
            end
        end
    end

    // Credit leaves on the edge after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            credit_free  <= 1'b0;
        end else begin
            credit_valid <= |win;
            credit_vc    <= idx;
            credit_free  <= frees && (|win);
        end
    end

endmodule

// File: rtl/vcin_unit.sv
// Router input port: per-VC buffering, head-flit routing, hold delay,
// credit return and per-virtual-network write/read counters.
// Assumes in_vc < NUM_VC, sa_grant one-hot-or-zero, NUM_VC divisible by
// VC_PER_VNET, PIPE_STAGES >= 1.
module vcin_unit
    import vcin_pkg::*;
#(
    parameter int NUM_VC      = 4,
    parameter int VC_PER_VNET = 2,
    parameter int BUF_DEPTH   = 4,
    parameter int PIPE_STAGES = 2,
    parameter int DATA_W      = 16,
    parameter int DEST_W      = 4,
    parameter int NUM_OUT     = 5,
    parameter int CNT_W       = 16,
    localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int OUT_W      = $clog2(NUM_OUT),
    localparam int NUM_VNET   = NUM_VC / VC_PER_VNET
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [VC_W-1:0]            in_vc,
    input  logic [1:0]                 in_kind,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       stats_clr,
    input  logic [NUM_VC-1:0]          sa_grant,
    output logic [NUM_VC-1:0]          sa_ready,
    output logic [2*NUM_VC-1:0]        sa_kind,
    output logic [DATA_W*NUM_VC-1:0]   sa_data,
    output logic [OUT_W*NUM_VC-1:0]    sa_port,
    output logic                       credit_valid,
    output logic [VC_W-1:0]            credit_vc,
    output logic                       credit_free,
    output logic                       proto_err,
    output logic [NUM_VNET*CNT_W-1:0]  vnet_wr_cnt,
    output logic [NUM_VNET*CNT_W-1:0]  vnet_rd_cnt
);

    localparam int HOLD = PIPE_STAGES - 1;

    logic [OUT_W-1:0]  route_port;
    logic [NUM_VC-1:0] lane_acc;
    logic [NUM_VC-1:0] lane_rej;
    logic [NUM_VC-1:0] lane_active;
    logic [NUM_VC-1:0] win;
    logic [NUM_VC-1:0] win_closes;

    vcin_route #(
        .DEST_W (DEST_W),
        .NUM_OUT(NUM_OUT),
        .OUT_W  (OUT_W)
    ) u_route (
        .dest(in_data[DEST_W-1:0]),
        .port(route_port)
    );

    for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
        logic [1:0] kind_v;

        vcin_lane #(
            .DATA_W(DATA_W),
            .DEPTH (BUF_DEPTH),
            .OUT_W (OUT_W),
            .HOLD  (HOLD)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_req    (in_valid && (in_vc == VC_W'(v))),
            .wr_kind   (in_kind),
            .wr_data   (in_data),
            .route_port(route_port),
            .pop_req   (sa_grant[v]),
            .accepted  (lane_acc[v]),
            .rejected  (lane_rej[v]),
            .ready     (sa_ready[v]),
            .front_data(sa_data[v*DATA_W +: DATA_W]),
            .front_kind(kind_v),
            .held_port (sa_port[v*OUT_W +: OUT_W]),
            .is_active (lane_active[v])
        );

        assign sa_kind[2*v +: 2] = kind_v;
        assign win[v]            = sa_grant[v] && sa_ready[v];
        assign win_closes[v]     = closes_pkt(kind_v);
    end

    vcin_credit #(
        .NUM_VC(NUM_VC),
        .VC_W  (VC_W)
    ) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .win         (win),
        .win_closes  (win_closes),
        .credit_valid(credit_valid),
        .credit_vc   (credit_vc),
        .credit_free (credit_free)
    );

    // Registered report of a refused flit.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= |lane_rej;
    end

    for (genvar n = 0; n < NUM_VNET; n++) begin : g_vnet
        logic             hit;
        logic [CNT_W-1:0] wr_q;
        logic [CNT_W-1:0] rd_q;

        assign hit = |lane_acc[n*VC_PER_VNET +: VC_PER_VNET];

        // Write and read tallies advance together; clear wins.
        always_ff @(posedge clk) begin
            if (!rst_n || stats_clr) begin
                wr_q <= '0;
                rd_q <= '0;
            end else if (hit) begin
                wr_q <= wr_q + 1'b1;
                rd_q <= rd_q + 1'b1;
            end
        end

        assign vnet_wr_cnt[n*CNT_W +: CNT_W] = wr_q;
        assign vnet_rd_cnt[n*CNT_W +: CNT_W] = rd_q;
    end

endmodule

// File: rtl/vcin_unit_chk.sv
// Temporal checks on the VC input port, bound into every vcin_unit.
module vcin_unit_chk #(
    parameter int NUM_VC   = 4,
    parameter int VC_W     = 2,
    parameter int NUM_VNET = 2,
    parameter int CNT_W    = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [VC_W-1:0]           in_vc,
    input logic [1:0]                in_kind,
    input logic                      stats_clr,
    input logic [NUM_VC-1:0]         sa_grant,
    input logic [NUM_VC-1:0]         sa_ready,
    input logic                      credit_valid,
    input logic [VC_W-1:0]           credit_vc,
    input logic                      credit_free,
    input logic                      proto_err,
    input logic [NUM_VC-1:0]         lane_active,
    input logic [NUM_VNET*CNT_W-1:0] vnet_wr_cnt,
    input logic [NUM_VNET*CNT_W-1:0] vnet_rd_cnt
);

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_grant));

    // R8
    credit_follows_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sa_grant & sa_ready)) |=> credit_valid);

    // R7
    no_unearned_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sa_grant & sa_ready)) |=> !credit_valid);

    // R3
    head_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[0] && lane_active[in_vc]) |=> proto_err);

    // R4
    body_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind[0] && !lane_active[in_vc]) |=> proto_err);

    // R2
    head_opens_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[0] && !lane_active[in_vc]) |=> lane_active[$past(in_vc)]);

    // R9
    free_releases_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_valid && credit_free) |-> !lane_active[credit_vc]);

    // R11
    stats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stats_clr |=> (vnet_wr_cnt == '0) && (vnet_rd_cnt == '0));

    // R10
    tallies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vnet_wr_cnt == vnet_rd_cnt);

endmodule

bind vcin_unit vcin_unit_chk #(
    .NUM_VC  (NUM_VC),
    .VC_W    (VC_W),
    .NUM_VNET(NUM_VNET),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_vc       (in_vc),
    .in_kind     (in_kind),
    .stats_clr   (stats_clr),
    .sa_grant    (sa_grant),
    .sa_ready    (sa_ready),
    .credit_valid(credit_valid),
    .credit_vc   (credit_vc),
    .credit_free (credit_free),
    .proto_err   (proto_err),
    .lane_active (lane_active),
    .vnet_wr_cnt (vnet_wr_cnt),
    .vnet_rd_cnt (vnet_rd_cnt)
);

// File: tb/vcin_unit_test.sv
module vcin_unit_test;

    localparam int NV = 4;
    localparam int DW = 16;
    localparam int OW = 3;
    localparam int CW = 16;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic        v;
        logic [1:0]  vc;
        logic [1:0]  kind;
        logic [15:0] data;
        logic [3:0]  grant;
        logic [3:0]  e_ready;
        logic        e_cv;
        logic [1:0]  e_cvc;
        logic        e_cf;
        logic        e_err;
        logic [2:0]  e_p0;
        logic [2:0]  e_p1;
    } step_t;

    // Kinds: 00 body, 01 head, 10 tail, 11 single. PIPE_STAGES = 2.
    localparam step_t STEPS [12] = '{
        '{1'b1, 2'd0, 2'b01, 16'h0007, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd0},
        '{1'b1, 2'd0, 2'b00, 16'h0011, 4'b0000, 4'b0001, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd0},
        '{1'b1, 2'd1, 2'b11, 16'h0003, 4'b0001, 4'b0001, 1'b1, 2'd0, 1'b0, 1'b0, 3'd2, 3'd3},
        '{1'b1, 2'd0, 2'b01, 16'h0000, 4'b0001, 4'b0010, 1'b1, 2'd0, 1'b0, 1'b1, 3'd2, 3'd3},
        '{1'b1, 2'd2, 2'b00, 16'h0000, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b1, 1'b1, 3'd2, 3'd0},
        '{1'b1, 2'd0, 2'b10, 16'h00A0, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd0},
        '{1'b1, 2'd1, 2'b01, 16'h0009, 4'b0000, 4'b0001, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd4},
        '{1'b0, 2'd0, 2'b00, 16'h0000, 4'b0001, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 3'd4},
        '{1'b0, 2'd0, 2'b00, 16'h0000, 4'b1000, 4'b0010, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd4},
        '{1'b1, 2'd1, 2'b10, 16'h00B0, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b0, 1'b0, 3'd0, 3'd4},
        '{1'b0, 2'd0, 2'b00, 16'h0000, 4'b0000, 4'b0010, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd4},
        '{1'b0, 2'd0, 2'b00, 16'h0000, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b1, 1'b0, 3'd0, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // main instance, PIPE_STAGES = 2
    logic              in_valid = 1'b0;
    logic [1:0]        in_vc = '0;
    logic [1:0]        in_kind = '0;
    logic [DW-1:0]     in_data = '0;
    logic              stats_clr = 1'b0;
    logic [NV-1:0]     sa_grant = '0;
    logic [NV-1:0]     sa_ready;
    logic [2*NV-1:0]   sa_kind;
    logic [DW*NV-1:0]  sa_data;
    logic [OW*NV-1:0]  sa_port;
    logic              credit_valid;
    logic [1:0]        credit_vc;
    logic              credit_free;
    logic              proto_err;
    logic [2*CW-1:0]   wr_cnt;
    logic [2*CW-1:0]   rd_cnt;

    // second instance, PIPE_STAGES = 1
    logic              q_valid = 1'b0;
    logic [1:0]        q_vc = '0;
    logic [1:0]        q_kind = '0;
    logic [DW-1:0]     q_data = '0;
    logic [NV-1:0]     q_grant = '0;
    logic [NV-1:0]     q_ready;
    logic [2*NV-1:0]   q_kind_o;
    logic [DW*NV-1:0]  q_data_o;
    logic [OW*NV-1:0]  q_port;
    logic              q_cv;
    logic [1:0]        q_cvc;
    logic              q_cf;
    logic              q_err;
    logic [2*CW-1:0]   q_wr;
    logic [2*CW-1:0]   q_rd;

    vcin_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
        .in_kind(in_kind), .in_data(in_data), .stats_clr(stats_clr),
        .sa_grant(sa_grant), .sa_ready(sa_ready), .sa_kind(sa_kind),
        .sa_data(sa_data), .sa_port(sa_port), .credit_valid(credit_valid),
        .credit_vc(credit_vc), .credit_free(credit_free), .proto_err(proto_err),
        .vnet_wr_cnt(wr_cnt), .vnet_rd_cnt(rd_cnt)
    );

    vcin_unit #(.PIPE_STAGES(1)) uut_p1 (
        .clk(clk), .rst_n(rst_n), .in_valid(q_valid), .in_vc(q_vc),
        .in_kind(q_kind), .in_data(q_data), .stats_clr(1'b0),
        .sa_grant(q_grant), .sa_ready(q_ready), .sa_kind(q_kind_o),
        .sa_data(q_data_o), .sa_port(q_port), .credit_valid(q_cv),
        .credit_vc(q_cvc), .credit_free(q_cf), .proto_err(q_err),
        .vnet_wr_cnt(q_wr), .vnet_rd_cnt(q_rd)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int credits [NV];

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < NV; v++) credits[v] = DEPTH;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        check("reset R6 ready", sa_ready, 0);
        check("reset R8 credit", credit_valid, 0);
        check("reset R3 err", proto_err, 0);
        check("reset R9 ports", sa_port, 0);
        check("reset R10 counters", wr_cnt, 0);

        // table walk on the PIPE_STAGES=2 instance
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = STEPS[i].v;
            in_vc    = STEPS[i].vc;
            in_kind  = STEPS[i].kind;
            in_data  = STEPS[i].data;
            sa_grant = STEPS[i].grant;
            if (STEPS[i].v) begin
                // R8 upstream only sends with a credit in hand
                check("R8 upstream credit available", credits[STEPS[i].vc] > 0, 1);
                credits[STEPS[i].vc]--;
            end
            step_edge();
            if (STEPS[i].v && STEPS[i].e_err) credits[STEPS[i].vc]++;
            if (credit_valid) credits[credit_vc]++;
            check($sformatf("R6/R7 ready step %0d", i), sa_ready, STEPS[i].e_ready);
            check($sformatf("R8 credit_valid step %0d", i), credit_valid, STEPS[i].e_cv);
            if (STEPS[i].e_cv) begin
                check($sformatf("R8 credit_vc step %0d", i), credit_vc, STEPS[i].e_cvc);
                check($sformatf("R8 credit_free step %0d", i), credit_free, STEPS[i].e_cf);
            end
            check($sformatf("R3/R4 proto_err step %0d", i), proto_err, STEPS[i].e_err);
            check($sformatf("R2/R9 port vc0 step %0d", i), sa_port[2:0], STEPS[i].e_p0);
            check($sformatf("R2/R9 port vc1 step %0d", i), sa_port[5:3], STEPS[i].e_p1);
            if (i == 1) begin
                check("R1 front data vc0", sa_data[15:0], 16'h0007);
                check("R1 front kind vc0", sa_kind[1:0], 2'b01);
            end
            if (i == 2) check("R1 front data vc0 after pop", sa_data[15:0], 16'h0011);
        end
        @(negedge clk);
        in_valid = 1'b0;
        sa_grant = '0;
        for (int v = 0; v < NV; v++)
            check($sformatf("R8 credits returned vc%0d", v), credits[v], DEPTH);
        check("R10 vnet0 writes", wr_cnt[15:0], 6);
        check("R10 vnet0 reads", rd_cnt[15:0], 6);
        check("R10 vnet1 untouched by rejects", wr_cnt[31:16], 0);

        // R10: write on vc2 lands in virtual network 1
        in_valid = 1'b1; in_vc = 2'd2; in_kind = 2'b11; in_data = 16'h0001;
        step_edge();
        check("R10 vnet1 writes", wr_cnt[31:16], 1);
        check("R10 vnet1 reads", rd_cnt[31:16], 1);
        check("R10 vnet0 unchanged", wr_cnt[15:0], 6);

        // R11: clear beats a same-cycle write
        @(negedge clk);
        in_vc = 2'd3; in_kind = 2'b01; in_data = 16'h0002; stats_clr = 1'b1;
        step_edge();
        check("R11 writes cleared", wr_cnt, 0);
        check("R11 reads cleared", rd_cnt, 0);
        check("R11 flit still stored", proto_err, 0);
        @(negedge clk);
        in_valid = 1'b0; stats_clr = 1'b0;
        step_edge();
        check("R11 stays clear", wr_cnt, 0);
        check("R2 port vc3", sa_port[11:9], 2);

        // PIPE_STAGES=1 instance: R6 and R5
        @(negedge clk);
        q_valid = 1'b1; q_vc = 2'd2; q_kind = 2'b01; q_data = 16'h0100;
        step_edge();
        check("R6 depth-1 ready at once", q_ready, 4'b0100);
        for (int k = 1; k < DEPTH; k++) begin
            @(negedge clk);
            q_kind = 2'b00; q_data = 16'h0100 + 16'(k);
            step_edge();
            check("R5 no error below full", q_err, 0);
        end
        @(negedge clk);
        q_data = 16'h0BAD;
        step_edge();
        check("R5 full FIFO rejects", q_err, 1);
        check("R1 front kept on overflow", q_data_o[47:32], 16'h0100);
        @(negedge clk);
        q_valid = 1'b0; q_grant = 4'b0100;
        step_edge();
        check("R8 depth-1 credit", q_cv, 1);
        check("R8 depth-1 credit vc", q_cvc, 2);
        check("R1 FIFO order", q_data_o[47:32], 16'h0101);
        check("R10 overflow not counted", q_wr[31:16], 4);
        @(negedge clk);
        q_grant = '0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule